// File: doc/BRIEF.md
# Dual-Side Differential Successive-Approximation Sequencer

This block sequences the bit trials of a fully differential successive-approximation converter built from two complementary capacitive DACs, each with its own comparator. In differential mode it first resolves a short, coarse code on the negative-side DAC using the low-power comparator. This pulls the negative comparator input close to the common-mode level, so the precision comparator then works inside its input range. It then resolves a full-length code on the positive-side DAC using the precision comparator. The raw, uncalibrated result is the positive code minus the negative code. The negative code is taken as it sits on the DAC, that is, aligned to the top bits of the full scale.

Each trial takes one clock cycle. The trial bit appears on the DAC output. The comparator answer is sampled at the end of that cycle, and the bit is kept when the answer is high. Single-ended mode skips the negative side entirely. A reduced 12-bit mode resolves only the upper twelve positive bits, which shortens the conversion. A start pulse, issued after sampling, launches a conversion. A one-cycle done pulse marks the cycle in which the result is valid.

States: `ST_IDLE` (waiting), `ST_NEG` (negative-side trials), `ST_POS` (positive-side trials), `ST_DONE` (result cycle). Transitions:
- idle-to-neg: start in differential mode.
- idle-to-pos: start in any other mode.
- neg-step: stay in `ST_NEG` while further negative trials remain.
- neg-to-pos: after the last negative trial.
- pos-step: stay in `ST_POS` while further positive trials remain.
- pos-to-done: after the last positive trial.
- done-to-idle: always, one cycle after entering `ST_DONE`.

Top module: `dsar_seq`

## Requirements
- R1: After reset, busy and done are low, both DAC codes are zero and the result is zero.
- R2: A start pulse in the idle state begins a conversion on the next clock and latches the mode. Mode encodings are: 2'b00 differential 16-bit, 2'b01 single-ended 16-bit, 2'b10 and 2'b11 reduced 12-bit single-ended.
- R3: In differential mode, the negative side runs NEG_STEPS trials (default 5), bit 15 downward, one per cycle. During each trial, dac_neg shows the bits kept so far plus the trial bit. The bit is kept when cmp_neg is high at the end of the cycle. dac_neg bits below the trialled range stay zero.
- R4: After the negative phase, the positive side runs its trials from bit 15 downward, one per cycle, controlled by cmp_pos. dac_neg holds its final code during this phase, and dac_pos stays zero during the negative phase.
- R5: In single-ended mode, no negative trials occur and dac_neg stays zero. The positive phase starts in the first cycle after start.
- R6: In the reduced mode, only bits 15 down to 4 are trialled, and dac_pos bits 3..0 remain zero.
- R7: done is high for exactly one cycle, in the cycle after the last trial: 22, 17 or 13 cycles after the start edge for differential, single-ended and reduced modes. busy is high exactly during trial cycles.
- R8: When done is high, result equals dac_pos minus dac_neg as a signed 17-bit value. The result and both DAC codes hold unchanged until the next accepted start.
- R9: A start pulse while busy or during the done cycle is ignored, and a change of mode during a conversion has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin conversion (accepted in idle only) |
| mode | input | 2 | Conversion mode, latched at start |
| cmp_neg | input | 1 | Coarse comparator: high keeps the negative trial bit |
| cmp_pos | input | 1 | Precision comparator: high keeps the positive trial bit |
| dac_neg | output | 16 | Negative-side DAC bit drive |
| dac_pos | output | 16 | Positive-side DAC bit drive |
| busy | output | 1 | Trial cycles in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 17 | Signed positive-minus-negative code |

## Verification
The assertions assume that the comparator inputs settle within the same cycle as the DAC trial they answer. They also assume that start is a clean synchronous level. The bench models each comparator as an ideal threshold between a held input voltage code and the current DAC output, so every comparator answer follows directly from the trial shown in that cycle. The bench changes the voltage codes and the mode only between conversions, except where it deliberately pokes start and mode mid-run to exercise R9.

// File: rtl/dsar_pkg.sv
package dsar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NEG  = 2'd1,
        ST_POS  = 2'd2,
        ST_DONE = 2'd3
    } dsar_state_t;

    localparam logic [1:0] MODE_DIFF = 2'b00;
    localparam logic [1:0] MODE_SE   = 2'b01;
endpackage

// File: rtl/sar_side.sv
module sar_side #(
    parameter int RES_W = 16,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step_en,
    input  logic [IDX_W-1:0] idx,
    input  logic             keep,
    output logic [RES_W-1:0] dac
);
    logic [RES_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (clear) begin
            code_q <= '0;
        end else if (step_en) begin
            code_q[idx] <= keep;
        end
    end

    always_comb begin
        dac = code_q;
        if (step_en) begin
            dac[idx] = 1'b1;
        end
    end
endmodule

// File: rtl/dsar_fsm.sv
module dsar_fsm
    import dsar_pkg::*;
#(
    parameter int RES_W     = 16,
    parameter int LOW_W     = 12,
    parameter int NEG_STEPS = 5,
    localparam int IDX_W    = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    output logic             clear,
    output logic             neg_en,
    output logic             pos_en,
    output logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic             done
);
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(RES_W - 1);
    localparam logic [IDX_W-1:0] NEG_LAST = IDX_W'(RES_W - NEG_STEPS);
    localparam logic [IDX_W-1:0] LOW_LAST = IDX_W'(RES_W - LOW_W);

    dsar_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [1:0]       mode_q, mode_d;
    logic [IDX_W-1:0] pos_last;

    assign pos_last = mode_q[1] ? LOW_LAST : '0;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        mode_d  = mode_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    mode_d  = mode;
                    idx_d   = TOP_IDX;
                    state_d = (mode == MODE_DIFF) ? ST_NEG : ST_POS;
                end
            end
            ST_NEG: begin
                if (idx_q == NEG_LAST) begin
                    idx_d   = TOP_IDX;
                    state_d = ST_POS;
                end else begin
                    idx_d = idx_q - 1'b1;
                end
            end
            ST_POS: begin
                if (idx_q == pos_last) begin
                    state_d = ST_DONE;
                end else begin
                    idx_d = idx_q - 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            mode_q  <= MODE_DIFF;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            mode_q  <= mode_d;
        end
    end

    always_comb begin
        clear  = 1'b0;
        neg_en = 1'b0;
        pos_en = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: clear = start;
            ST_NEG: begin
                neg_en = 1'b1;
                busy   = 1'b1;
            end
            ST_POS: begin
                pos_en = 1'b1;
                busy   = 1'b1;
            end
            ST_DONE: done = 1'b1;
        endcase
    end

    assign idx = idx_q;
endmodule

// File: rtl/dsar_diff.sv
module dsar_diff #(
    parameter int RES_W = 16
) (
    input  logic [RES_W-1:0]        pos_code,
    input  logic [RES_W-1:0]        neg_code,
    output logic signed [RES_W:0]   diff
);
    assign diff = $signed({1'b0, pos_code}) - $signed({1'b0, neg_code});
endmodule

// File: rtl/dsar_seq.sv
module dsar_seq #(
    parameter int RES_W     = 16,
    parameter int LOW_W     = 12,
    parameter int NEG_STEPS = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            mode,
    input  logic                  cmp_neg,
    input  logic                  cmp_pos,
    output logic [RES_W-1:0]      dac_neg,
    output logic [RES_W-1:0]      dac_pos,
    output logic                  busy,
    output logic                  done,
    output logic signed [RES_W:0] result
);
    localparam int IDX_W = $clog2(RES_W);

    logic             clear, neg_en, pos_en;
    logic [IDX_W-1:0] idx;

    dsar_fsm #(
        .RES_W(RES_W), .LOW_W(LOW_W), .NEG_STEPS(NEG_STEPS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .clear(clear), .neg_en(neg_en), .pos_en(pos_en), .idx(idx),
        .busy(busy), .done(done)
    );

    sar_side #(.RES_W(RES_W)) u_neg (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step_en(neg_en),
        .idx(idx), .keep(cmp_neg), .dac(dac_neg)
    );

    sar_side #(.RES_W(RES_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step_en(pos_en),
        .idx(idx), .keep(cmp_pos), .dac(dac_pos)
    );

    dsar_diff #(.RES_W(RES_W)) u_diff (
        .pos_code(dac_pos), .neg_code(dac_neg), .diff(result)
    );
endmodule

// File: rtl/dsar_seq_chk.sv
module dsar_seq_chk #(
    parameter int RES_W     = 16,
    parameter int NEG_STEPS = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic [RES_W-1:0]      dac_neg,
    input logic [RES_W-1:0]      dac_pos,
    input logic                  busy,
    input logic                  done,
    input logic signed [RES_W:0] result
);
    localparam logic [RES_W-1:0] BELOW_MASK = RES_W'((1 << (RES_W - NEG_STEPS)) - 1);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    neg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_neg & BELOW_MASK) == '0);

    // R4
    neg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && ($past(dac_pos) != '0)) |-> $stable(dac_neg));

    // R8
    result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == ($signed({1'b0, dac_pos}) - $signed({1'b0, dac_neg}))));
endmodule

bind dsar_seq dsar_seq_chk #(.RES_W(RES_W), .NEG_STEPS(NEG_STEPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .dac_neg(dac_neg),
    .dac_pos(dac_pos), .busy(busy), .done(done), .result(result)
);

// File: tb/dsar_seq_test.sv
module dsar_seq_test;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         mode = 2'b00;
    logic               cmp_neg, cmp_pos;
    logic [15:0]        dac_neg, dac_pos;
    logic               busy, done;
    logic signed [16:0] result;
    logic [15:0]        vin_p = '0, vin_n = '0;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // ideal comparators: keep the trial bit when input is at or above the trial code
    assign cmp_pos = (vin_p >= dac_pos);
    assign cmp_neg = (vin_n >= dac_neg);

    dsar_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .cmp_neg(cmp_neg), .cmp_pos(cmp_pos), .dac_neg(dac_neg),
        .dac_pos(dac_pos), .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int trial(input int v, input int idx);
        return (v & ~((1 << (idx + 1)) - 1) & 16'hFFFF) | (1 << idx);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            summary();
            $finish;
        end
    end

    // one conversion, compared against the behavioural model on every cycle
    task automatic run(input logic [1:0] m, input logic [15:0] vp, input logic [15:0] vn, input bit poke);
        int ns, np, pf, nf, ex;
        ns = (m == 2'b00) ? 5 : 0;
        np = m[1] ? 12 : 16;
        pf = m[1] ? (vp & 16'hFFF0) : vp;
        nf = (m == 2'b00) ? (vn & 16'hF800) : 0;
        ex = pf - nf;
        @(negedge clk);
        vin_p = vp; vin_n = vn; mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= ns + np + 1; c++) begin
            // R7 busy window and done position
            check(busy == (c <= ns + np), "R7 busy", busy, c <= ns + np);
            check(done == (c == ns + np + 1), "R7 done", done, c == ns + np + 1);
            if (c <= ns) begin
                check(dac_neg == trial(vn, 16 - c), "R3 neg trial", dac_neg, trial(vn, 16 - c));
                check(dac_pos == 0, "R4 pos idle in neg phase", dac_pos, 0);
            end else if (c <= ns + np) begin
                check(dac_pos == trial(vp, 15 - (c - ns - 1)), "R4 pos trial",
                      dac_pos, trial(vp, 15 - (c - ns - 1)));
                check(dac_neg == nf, "R4 R5 neg hold", dac_neg, nf);
            end else begin
                check(int'(result) == ex, "R8 result", int'(result), ex);
                check(dac_pos == pf, "R6 pos final", dac_pos, pf);
                check(dac_neg == nf, "R5 neg final", dac_neg, nf);
            end
            if (poke && c == 3) begin start = 1'b1; mode = ~m; end
            if (poke && c == 4) begin start = 1'b0; end
            if (poke && c == ns + np + 1) start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        mode = m;
        // R9 start during done ignored; R8 result held in idle
        check(!busy && !done, "R9 no restart", busy, 0);
        check(int'(result) == ex, "R8 result held", int'(result), ex);
        @(negedge clk);
        check(int'(result) == ex && dac_pos == pf, "R8 codes held", int'(result), ex);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 flags", {busy, done}, 0);
        check(dac_neg == 0 && dac_pos == 0, "R1 dacs", dac_pos | dac_neg, 0);
        check(result == 0, "R1 result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 differential conversions with several input patterns
        run(2'b00, 16'hBEEF, 16'h4321, 1'b0);
        run(2'b00, 16'h0000, 16'hFFFF, 1'b0);
        run(2'b00, 16'hFFFF, 16'h0000, 1'b0);
        run(2'b00, 16'h8000, 16'h7FFF, 1'b0);
        // R9 pokes during a run
        run(2'b00, 16'h1357, 16'hC0DE, 1'b1);
        // R5 single-ended
        run(2'b01, 16'h1234, 16'hFFFF, 1'b0);
        run(2'b01, 16'hFFFF, 16'h8000, 1'b1);
        // R6 reduced mode, both encodings
        run(2'b10, 16'hABCD, 16'h5555, 1'b0);
        run(2'b11, 16'h000F, 16'hFFFF, 1'b1);
        finished = 1;
        summary();
        $finish;
    end
endmodule